// File: doc/BRIEF.md
# Configurable TDM Audio Serializer

This block moves multichannel audio as a time-division multiplexed bit stream. A frame holds a fixed number of 32-bit slots, sent back to back with the most significant bit first. One serial pin carries outgoing data, changing on one edge of the bit clock. A second pin is sampled on the opposite edge. Slot words enter and leave as parallel words through valid/ready handshakes.

The bit clock and the frame sync either come from a divider clocked by the system clock, or arrive from outside. An external bit clock and frame sync each pass through a two-flop synchronizer, and their edges are found in the system clock domain. At run time, configuration inputs choose the following:
- whether the frame sync lasts one bit or one whole slot;
- how many bit periods (0, 1 or 2) the first data bit lags the frame sync;
- which bit-clock edge launches data and which samples it.

A missing transmit word produces a zero slot and a sticky underrun flag. An unread receive word that gets overwritten sets a sticky overrun flag. The configuration is held stable while the port runs and is changed only under reset.

Top module: `tdm_serializer`

## Requirements
- R1: A frame is SLOTS slots of 32 bits each, sent with no gap between slots. Each slot word is shifted MSB first, and accepted transmit words occupy slots in acceptance order starting at slot 0.
- R2: With cfg_fs_slot=0 the generated fs_o stays high for exactly one bit period per frame. With cfg_fs_slot=1 it stays high for exactly 32 bit periods.
- R3: The MSB of slot 0 appears cfg_dly bit periods after the bit period in which the frame sync goes high (cfg_dly 0, 1 or 2). Received words use the same alignment.
- R4: With cfg_pol=0, tx_o changes only together with a rising edge of the bit clock, and rx_i is sampled on the falling edge.
- R5: With cfg_pol=1, tx_o changes only together with a falling edge of the bit clock, and rx_i is sampled on the rising edge.
- R6: In internal mode (cfg_ext=0), bclk_o has a period of exactly 2*cfg_half system clock cycles, with cfg_half of 1 or more. This gives a ratio of at least 2.
- R7: With cfg_ext=1, the bit clock and the frame sync are taken from bclk_i and fs_i through two-flop synchronizers. A rising frame sync restarts the frame at slot 0, bit 0, even mid-frame.
- R8: tx_ready is a one-cycle pulse at the launch edge that starts a slot while tx_valid is high, and tx_data is taken in that cycle.
- R9: If tx_valid is low when a slot starts, that slot is sent as all zeros and the sticky underrun output becomes 1 until reset.
- R10: A completed received slot is presented as rx_data with its slot number on rx_slot and rx_valid=1. rx_valid stays high until rx_ready is high. A word completed while the previous one is unread replaces it and sets the sticky overrun output.
- R11: While rst is high, bclk_o, fs_o, tx_o, tx_ready, rx_valid, underrun and overrun are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ext | input | 1 | 1: bit clock and frame sync come from bclk_i and fs_i |
| cfg_pol | input | 1 | 0: launch on rising edge, sample on falling edge; 1: the reverse |
| cfg_fs_slot | input | 1 | 0: one-bit frame sync; 1: one-slot frame sync |
| cfg_dly | input | 2 | Data lag after frame sync in bit periods (0 to 2) |
| cfg_half | input | HALF_W | Half bit period in system clock cycles (1 or more) |
| bclk_i | input | 1 | External bit clock |
| fs_i | input | 1 | External frame sync |
| bclk_o | output | 1 | Generated bit clock (0 in external mode) |
| fs_o | output | 1 | Generated frame sync (0 in external mode) |
| tx_o | output | 1 | Serial transmit data |
| rx_i | input | 1 | Serial receive data |
| tx_data | input | 32 | Transmit slot word |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_data | output | 32 | Received slot word |
| rx_slot | output | SLOT_W | Slot number of rx_data |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Received word taken |
| underrun | output | 1 | Sticky: a slot started with no transmit word |
| overrun | output | 1 | Sticky: an unread received word was overwritten |

## Verification
The embedded assertions check the following on every cycle:
- launch and capture strobes never fall in the same cycle;
- a one-bit frame sync drops at the next launch;
- tx_ready is never high for two cycles in a row;
- an underrun slot begins with a zero bit;
- rx_valid holds until it is taken;
- both error flags stay set once set.

Only the bench's scenarios can show the remaining behaviour. They decode the pins at the sampling edge to recover slot words at each delay and sync width. They measure the bit-clock period, and tie every data transition to the launch edge of the selected polarity. They also check loopback words against the accepted transmit sequence, and check that an externally supplied frame sync arriving mid-frame realigns the frame.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam int SLOT_BITS = 32;

    typedef struct packed {
        logic       ext;
        logic       pol;
        logic       fs_slot;
        logic [1:0] dly;
    } tdm_cfg_t;

    typedef struct packed {
        logic launch;
        logic capture;
    } tdm_edge_t;

    // Position of the data bit carried at a frame position, after the sync lag.
    function automatic int data_idx(input int pos, input int dly, input int frame_bits);
        int d;
        d = pos - dly;
        if (d < 0) d = d + frame_bits;
        return d;
    endfunction
endpackage

// File: rtl/tdm_sync.sv
module tdm_sync (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;
    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tdm_bitclk.sv
module tdm_bitclk
    import tdm_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  tdm_cfg_t          cfg,
    input  logic [HALF_W-1:0] half,
    input  logic              bclk_i,
    input  logic              fs_i,
    output logic              bclk_o,
    output logic              fs_s,
    output tdm_edge_t         edges
);
    localparam int NSYNC = 2;

    logic [HALF_W-1:0] cnt;
    logic              bclk_q;
    logic              tick;
    logic [NSYNC-1:0]  raw_in, sync_q;
    logic              bclk_d;
    logic              rise, fall;

    assign tick = (cnt == half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || cfg.ext) begin
            cnt    <= '0;
            bclk_q <= 1'b0;
        end else if (tick) begin
            cnt    <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign raw_in = {fs_i, bclk_i};
    for (genvar i = 0; i < NSYNC; i++) begin : g_sync
        tdm_sync u_sync (.clk(clk), .rst(rst), .d(raw_in[i]), .q(sync_q[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) bclk_d <= 1'b0;
        else     bclk_d <= sync_q[0];
    end

    always_comb begin
        if (cfg.ext) begin
            rise = sync_q[0] & ~bclk_d;
            fall = ~sync_q[0] & bclk_d;
        end else begin
            rise = tick & ~bclk_q;
            fall = tick & bclk_q;
        end
        rise = rise & ~rst;
        fall = fall & ~rst;
        edges.launch  = cfg.pol ? fall : rise;
        edges.capture = cfg.pol ? rise : fall;
    end

    assign bclk_o = bclk_q;
    assign fs_s   = sync_q[1];

    a_r4_edges_apart: assert property (@(posedge clk) disable iff (rst)
        !(edges.launch && edges.capture));
    a_r6_half_nonzero: assert property (@(posedge clk) disable iff (rst)
        !cfg.ext |-> half != '0);
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 launch,
    input  logic                 slot_start,
    input  logic [SLOT_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic                 tx_o,
    output logic                 underrun
);
    logic [SLOT_BITS-1:0] sh;
    logic [SLOT_BITS-1:0] word;

    assign tx_ready = launch & slot_start & tx_valid;
    assign word     = tx_valid ? tx_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            tx_o     <= 1'b0;
            underrun <= 1'b0;
        end else if (launch) begin
            if (slot_start) begin
                tx_o <= word[SLOT_BITS-1];
                sh   <= {word[SLOT_BITS-2:0], 1'b0};
                if (!tx_valid) underrun <= 1'b1;
            end else begin
                tx_o <= sh[SLOT_BITS-1];
                sh   <= {sh[SLOT_BITS-2:0], 1'b0};
            end
        end
    end

    a_r8_ready_single: assert property (@(posedge clk) disable iff (rst)
        tx_ready |=> !tx_ready);
    a_r9_zero_slot: assert property (@(posedge clk) disable iff (rst)
        (launch && slot_start && !tx_valid) |=> !tx_o);
    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
    import tdm_pkg::*;
#(
    parameter int SLOT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 capture,
    input  logic                 word_end,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic                 rx_i,
    output logic [SLOT_BITS-1:0] rx_data,
    output logic [SLOT_W-1:0]    rx_slot,
    output logic                 rx_valid,
    input  logic                 rx_ready,
    output logic                 overrun
);
    logic [SLOT_BITS-1:0] sh;
    logic [SLOT_BITS-1:0] sh_nx;

    assign sh_nx = {sh[SLOT_BITS-2:0], rx_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            rx_data  <= '0;
            rx_slot  <= '0;
            rx_valid <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (rx_valid && rx_ready) rx_valid <= 1'b0;
            if (capture) begin
                sh <= sh_nx;
                if (word_end) begin
                    rx_data  <= sh_nx;
                    rx_slot  <= slot_idx;
                    rx_valid <= 1'b1;
                    if (rx_valid && !rx_ready) overrun <= 1'b1;
                end
            end
        end
    end

    a_r10_hold_valid: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> rx_valid);
    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer
    import tdm_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int HALF_W = 8,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_ext,
    input  logic                 cfg_pol,
    input  logic                 cfg_fs_slot,
    input  logic [1:0]           cfg_dly,
    input  logic [HALF_W-1:0]    cfg_half,
    input  logic                 bclk_i,
    input  logic                 fs_i,
    output logic                 bclk_o,
    output logic                 fs_o,
    output logic                 tx_o,
    input  logic                 rx_i,
    input  logic [SLOT_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic [SLOT_BITS-1:0] rx_data,
    output logic [SLOT_W-1:0]    rx_slot,
    output logic                 rx_valid,
    input  logic                 rx_ready,
    output logic                 underrun,
    output logic                 overrun
);
    localparam int FRAME_BITS = SLOTS * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);

    tdm_cfg_t   cfg;
    tdm_edge_t  edges;
    logic       fs_s, fs_prev, fs_start, last;
    logic [POS_W-1:0]  pos, pos_nx;
    int         d_nx, d_cur;
    logic       slot_start, word_end;
    logic [SLOT_W-1:0] slot_idx;

    assign cfg = '{ext: cfg_ext, pol: cfg_pol, fs_slot: cfg_fs_slot, dly: cfg_dly};

    tdm_bitclk #(.HALF_W(HALF_W)) u_clk (
        .clk(clk), .rst(rst), .cfg(cfg), .half(cfg_half),
        .bclk_i(bclk_i), .fs_i(fs_i),
        .bclk_o(bclk_o), .fs_s(fs_s), .edges(edges)
    );

    // Frame position tracker: advances on every launch edge.
    always_comb begin
        last     = (pos == POS_W'(FRAME_BITS - 1));
        fs_start = cfg.ext ? (fs_s & ~fs_prev) : last;
        pos_nx   = (fs_start || last) ? '0 : pos + 1'b1;
        d_nx     = data_idx(int'(pos_nx), int'(cfg.dly), FRAME_BITS);
        d_cur    = data_idx(int'(pos), int'(cfg.dly), FRAME_BITS);
        slot_start = (d_nx % SLOT_BITS) == 0;
        word_end   = (d_cur % SLOT_BITS) == SLOT_BITS - 1;
        slot_idx   = SLOT_W'(d_cur / SLOT_BITS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= POS_W'(FRAME_BITS - 1);
            fs_prev <= 1'b0;
            fs_o    <= 1'b0;
        end else if (edges.launch) begin
            pos     <= pos_nx;
            fs_prev <= fs_s;
            if (cfg.ext)          fs_o <= 1'b0;
            else if (cfg.fs_slot) fs_o <= (int'(pos_nx) < SLOT_BITS);
            else                  fs_o <= (pos_nx == '0);
        end
    end

    tdm_tx u_tx (
        .clk(clk), .rst(rst), .launch(edges.launch), .slot_start(slot_start),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_o(tx_o), .underrun(underrun)
    );

    tdm_rx #(.SLOT_W(SLOT_W)) u_rx (
        .clk(clk), .rst(rst), .capture(edges.capture), .word_end(word_end),
        .slot_idx(slot_idx), .rx_i(rx_i), .rx_data(rx_data), .rx_slot(rx_slot),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .overrun(overrun)
    );

    a_r2_bit_sync_short: assert property (@(posedge clk) disable iff (rst)
        (!cfg.ext && !cfg.fs_slot && fs_o && edges.launch) |=> !fs_o);
    a_r7_ext_no_sync_out: assert property (@(posedge clk) disable iff (rst)
        (cfg.ext && edges.launch) |=> !fs_o);
endmodule

// File: tb/sim_tdm_serializer.sv
module sim_tdm_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS = 4;
    localparam int FRAME = SLOTS * 32;
    localparam int HW = 8;
    localparam int EXT_HALF = 4;
    localparam int IDLE_BITS = 5;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_ext = 0, cfg_pol = 0, cfg_fs_slot = 0;
    logic [1:0] cfg_dly = 0;
    logic [HW-1:0] cfg_half = 1;
    logic bclk_i = 0, fs_i = 0;
    logic bclk_o, fs_o, tx_o, rx_i;
    logic [31:0] tx_data = 0;
    logic tx_valid = 0, tx_ready;
    logic [31:0] rx_data;
    logic [1:0] rx_slot;
    logic rx_valid, rx_ready = 1;
    logic underrun, overrun;

    assign rx_i = tx_o;

    tdm_serializer #(.SLOTS(SLOTS), .HALF_W(HW)) u0 (
        .clk(clk), .rst(rst), .cfg_ext(cfg_ext), .cfg_pol(cfg_pol),
        .cfg_fs_slot(cfg_fs_slot), .cfg_dly(cfg_dly), .cfg_half(cfg_half),
        .bclk_i(bclk_i), .fs_i(fs_i), .bclk_o(bclk_o), .fs_o(fs_o), .tx_o(tx_o),
        .rx_i(rx_i), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_slot(rx_slot), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .underrun(underrun), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, failures = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Monitor state
    logic [31:0] sent [0:63];
    int n_sent, rx_idx, rx_good, rx_bad, skip;
    bit rx_started, mon_en, take;
    int cyc, last_rise, n_per, per_bad, align_bad;
    int frame_no, c, fs_hi, pin_words, pin_bad, fs_chk, fs_bad;
    logic prev_bclk, prev_tx, prev_fs;
    logic [31:0] acc, exp_w;

    function automatic logic [31:0] sent_at(input int k);
        return (k < n_sent) ? sent[k] : 32'h0;
    endfunction

    initial begin
        forever begin
            @(posedge clk); #1;
            if (take) begin tx_data = $urandom; take = 0; end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (mon_en) begin
                cyc++;
                if (tx_ready) begin
                    if (n_sent < 64) sent[n_sent] = tx_data;
                    n_sent++;
                    take = 1;
                end
                if (rx_valid && rx_ready) begin
                    if (!rx_started && rx_slot == 0) rx_started = 1;
                    if (rx_started) begin
                        exp_w = sent_at(rx_idx + skip);
                        if (rx_data == exp_w && int'(rx_slot) == rx_idx % SLOTS) rx_good++;
                        else begin
                            rx_bad++;
                            $display("FAIL R10 loopback word actual=%0h expected=%0h", rx_data, exp_w);
                        end
                        rx_idx++;
                    end
                end
                if (!cfg_ext) begin
                    if (tx_o !== prev_tx &&
                        !(bclk_o !== prev_bclk && bclk_o == !cfg_pol)) align_bad++;
                    if (bclk_o !== prev_bclk) begin
                        if (bclk_o) begin
                            if (last_rise >= 0) begin
                                n_per++;
                                if (cyc - last_rise != 2 * int'(cfg_half)) per_bad++;
                            end
                            last_rise = cyc;
                        end
                        if (bclk_o == cfg_pol) begin
                            if (fs_o && !prev_fs) begin
                                frame_no++; c = 0; fs_hi = 0; acc = 0;
                            end else c++;
                            if (fs_o) fs_hi++;
                            if (frame_no >= 0 && c >= int'(cfg_dly) && c < int'(cfg_dly) + 32)
                                acc = {acc[30:0], tx_o};
                            if (frame_no >= 0 && c == int'(cfg_dly) + 31) begin
                                pin_words++;
                                if (acc != sent_at(frame_no * SLOTS)) begin
                                    pin_bad++;
                                    $display("FAIL R3 R1 pin word actual=%0h expected=%0h",
                                             acc, sent_at(frame_no * SLOTS));
                                end
                            end
                            if (frame_no >= 0 && c == 40) begin
                                fs_chk++;
                                if (fs_hi != (cfg_fs_slot ? 32 : 1)) fs_bad++;
                            end
                            prev_fs = fs_o;
                        end
                    end
                end
                prev_bclk = bclk_o;
                prev_tx = tx_o;
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic run(input bit ext, input bit pol, input bit fsw, input int dly,
                       input int half, input bit txv, input bit rxr, input string tag);
        mon_en = 0;
        rst = 1;
        cfg_ext = ext; cfg_pol = pol; cfg_fs_slot = fsw; cfg_dly = 2'(dly);
        cfg_half = HW'(half);
        tx_valid = txv; rx_ready = rxr; tx_data = $urandom;
        bclk_i = pol; fs_i = 0;
        wait_cyc(3);
        @(negedge clk);
        // R11: reset state
        chk(!bclk_o && !fs_o && !tx_o && !tx_ready && !rx_valid && !underrun && !overrun,
            {"R11 reset ", tag}, {bclk_o, fs_o, tx_o, tx_ready, rx_valid, underrun, overrun}, 0);
        n_sent = 0; rx_idx = 0; rx_good = 0; rx_bad = 0; rx_started = 0; take = 0;
        skip = ext ? 1 : 0;
        cyc = 0; last_rise = -1; n_per = 0; per_bad = 0; align_bad = 0;
        frame_no = -1; c = 1000; fs_hi = 0; pin_words = 0; pin_bad = 0; fs_chk = 0; fs_bad = 0;
        prev_bclk = 0; prev_tx = 0; prev_fs = 0; acc = 0;
        mon_en = 1;
        @(posedge clk); #1;
        rst = 0;
        if (!ext) begin
            wait_cyc(3 * FRAME * 2 * half + 120);
        end else begin
            for (int b = 0; b < IDLE_BITS + 3 * FRAME; b++) begin
                int p;
                p = b - IDLE_BITS;
                bclk_i = !pol;
                fs_i = (p >= 0) && (fsw ? ((p % FRAME) < 32) : ((p % FRAME) == 0));
                wait_cyc(EXT_HALF);
                bclk_i = pol;
                wait_cyc(EXT_HALF);
            end
            wait_cyc(20);
        end
        @(negedge clk);
        if (!ext) begin
            chk(per_bad == 0 && n_per > 10, {"R6 bit clock period ", tag}, per_bad, 0);
            chk(align_bad == 0, pol ? {"R5 falling launch ", tag} : {"R4 rising launch ", tag},
                align_bad, 0);
            chk(pin_bad == 0 && pin_words >= 2, {"R3 R1 pin decode ", tag}, pin_bad, 0);
            chk(fs_bad == 0 && fs_chk >= 2, {"R2 sync width ", tag}, fs_bad, 0);
        end
        if (rxr)
            chk(rx_bad == 0 && rx_good >= 2 * SLOTS,
                ext ? {"R7 external loopback ", tag} : {"R10 loopback ", tag}, rx_good, 2 * SLOTS);
        else
            chk(rx_valid && overrun, {"R10 overrun ", tag}, {rx_valid, overrun}, 3);
        if (rxr) chk(!overrun, {"R10 no overrun ", tag}, overrun, 0);
        chk(underrun == !txv, {"R9 underrun flag ", tag}, underrun, !txv);
        if (txv) chk(n_sent >= 2 * SLOTS, {"R8 words taken ", tag}, n_sent, 2 * SLOTS);
        else     chk(n_sent == 0, {"R8 no take ", tag}, n_sent, 0);
    endtask

    initial begin
        int h;
        void'($urandom(32'd1234));
        run(0, 0, 0, 0, 2, 1, 1, "int p0 d0 bit");
        run(0, 1, 1, 1, 3, 1, 1, "int p1 d1 slot");
        run(0, 0, 1, 2, 1, 1, 1, "int p0 d2 slot");
        h = 1 + int'($urandom % 4);
        run(0, 1, 0, 2, h, 1, 1, "int p1 d2 bit rnd");
        run(1, 0, 0, 1, 1, 1, 1, "ext p0 d1 bit");
        run(1, 1, 1, 0, 1, 1, 1, "ext p1 d0 slot");
        run(0, 0, 0, 1, 2, 0, 1, "underrun");
        run(0, 1, 1, 0, 1, 1, 0, "overrun");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule